// File: doc/BRIEF.md
# Dual-Bank Programmable Interrupt Controller

This block gathers 32 interrupt request lines and presents them to a processor as two independent interrupt outputs: a normal request and a fast request. Each output is served by its own bank of six registers. Through these registers software chooses, per line, level or edge sensing and active polarity, enables lines, acknowledges latched edges and reads the raw and masked views.

Every input first passes a two-flop synchroniser. Each bank applies its own polarity to the synchronised value. In edge mode a bank sets a sticky pending bit on the chosen edge. In level mode the pending state follows the adjusted input. The masked pending bits of a bank are OR-reduced, and the result is registered to drive that bank's output. Access is through a plain word-addressed 32-bit write/read port. Reads are combinational.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset every mask, mode, polarity and pending bit is zero, and both outputs are low.
- R2: Byte offsets give the banks. Offsets 0x00–0x14 hold the normal bank (raw view 0x00, enable 0x04, acknowledge 0x08, mode 0x0C, polarity 0x10, masked view 0x14). The fast bank repeats the same layout at 0x20–0x34. Enable, mode and polarity read back what was written, and each bank is independent of the other. Bit n of every register is line n.
- R3: Mode bit 0 selects level sensing. The pending state then equals the polarity-adjusted synchronised input, and an acknowledge write does not change it.
- R4: Mode bit 1 selects edge sensing. Polarity 0 means a rising edge and polarity 1 means a falling edge. The chosen edge sets a pending bit that stays set after the input returns. The opposite edge sets nothing.
- R5: Writing the acknowledge register clears the latched pending bits whose data bit is 1. Bits written 0 leave their line untouched.
- R6: The raw view reads the synchronised inputs XOR polarity. The masked view reads pending AND enable, where enable 1 means the line is allowed.
- R7: Each output is the OR of its bank's masked view, registered once. A level input change at the pins is seen at the output three rising edges later. Activity in one bank never drives the other bank's output.
- R8: Reads of the acknowledge offsets, of 0x18, 0x1C, 0x38 and above, and of any offset that is not a multiple of 4 return zero.
- R9: If an acknowledge write and a new selected edge hit the same line in the same cycle, the line ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_in | input | 32 | Asynchronous interrupt request lines |
| wr_en | input | 1 | Register write strobe for one cycle |
| addr | input | 8 | Byte offset for the read and the write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_out | output | 1 | Normal-bank interrupt output |
| fiq_out | output | 1 | Fast-bank interrupt output |

## Verification
The hardest case to reach is an acknowledge write that lands in the same cycle as a fresh edge on the same line. The edge reaches the latch only after the two synchroniser stages. The bench therefore changes the line at a falling clock edge, waits exactly two cycles, and then issues a write that clears both that line and an older pending line. Afterwards the older line must be clear and the new line must still be pending. The three-edge delay from pin to output is checked cycle by cycle on a level line.

// File: rtl/dual_bank_intc.sv
module dual_bank_intc #(
  parameter int NLINES = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lines_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NLINES-1:0] wdata,
  output logic [NLINES-1:0] rdata,
  output logic              irq_out,
  output logic              fiq_out
);
  localparam int NBANK = 2;
  localparam logic [4:0] OFF_SRC  = 5'h00;
  localparam logic [4:0] OFF_MASK = 5'h04;
  localparam logic [4:0] OFF_CLR  = 5'h08;
  localparam logic [4:0] OFF_MODE = 5'h0C;
  localparam logic [4:0] OFF_POL  = 5'h10;
  localparam logic [4:0] OFF_STAT = 5'h14;

  logic [NLINES-1:0] sync1, sync2, sync3;
  logic [NLINES-1:0] mask_r [NBANK];
  logic [NLINES-1:0] mode_r [NBANK];
  logic [NLINES-1:0] pol_r  [NBANK];
  logic [NLINES-1:0] lat_r  [NBANK];
  logic [NLINES-1:0] adj    [NBANK];
  logic [NLINES-1:0] edge_hit [NBANK];
  logic [NLINES-1:0] clr_w  [NBANK];
  logic [NLINES-1:0] stat   [NBANK];
  logic              out_r  [NBANK];

  wire in_map = (addr[ADDR_W-1:6] == '0);
  wire [4:0] off = addr[4:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= lines_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic wsel;
    assign wsel        = wr_en && in_map && (addr[5] == 1'(b));
    assign adj[b]      = sync2 ^ pol_r[b];
    assign edge_hit[b] = adj[b] & ~(sync3 ^ pol_r[b]);
    assign clr_w[b]    = (wsel && off == OFF_CLR) ? wdata : '0;
    assign stat[b]     = ((mode_r[b] & lat_r[b]) | (~mode_r[b] & adj[b])) & mask_r[b];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        mask_r[b] <= '0;
        mode_r[b] <= '0;
        pol_r[b]  <= '0;
        lat_r[b]  <= '0;
        out_r[b]  <= 1'b0;
      end else begin
        if (wsel && off == OFF_MASK) mask_r[b] <= wdata;
        if (wsel && off == OFF_MODE) mode_r[b] <= wdata;
        if (wsel && off == OFF_POL)  pol_r[b]  <= wdata;
        lat_r[b] <= ((lat_r[b] & ~clr_w[b]) | edge_hit[b]) & mode_r[b];
        out_r[b] <= |stat[b];
      end
  end

  always_comb begin
    rdata = '0;
    if (in_map)
      case (off)
        OFF_SRC:  rdata = adj[addr[5]];
        OFF_MASK: rdata = mask_r[addr[5]];
        OFF_MODE: rdata = mode_r[addr[5]];
        OFF_POL:  rdata = pol_r[addr[5]];
        OFF_STAT: rdata = stat[addr[5]];
        default:  rdata = '0;
      endcase
  end

  assign irq_out = out_r[0];
  assign fiq_out = out_r[1];
endmodule

// File: rtl/dual_bank_intc_chk.sv
module dual_bank_intc_chk #(
  parameter int NLINES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_out,
  input logic              fiq_out,
  input logic [NLINES-1:0] mask0,
  input logic [NLINES-1:0] stat0,
  input logic [NLINES-1:0] stat1,
  input logic [NLINES-1:0] mode1,
  input logic [NLINES-1:0] lat1,
  input logic [NLINES-1:0] edge1,
  input logic [NLINES-1:0] clr1
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!irq_out && !fiq_out));

  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == (|$past(stat0))));

  assert_fiq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fiq_out == (|$past(stat1))));

  assert_masked_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask0 == '0) |=> !irq_out);

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lat1 & mode1 & ~clr1) & ~lat1) == '0));

  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr1 & ~edge1) & lat1) == '0));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge1 & mode1) & ~lat1) == '0));
endmodule

bind dual_bank_intc dual_bank_intc_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .fiq_out(fiq_out),
  .mask0(mask_r[0]), .stat0(stat[0]), .stat1(stat[1]),
  .mode1(mode_r[1]), .lat1(lat_r[1]), .edge1(edge_hit[1]), .clr1(clr_w[1])
);

// File: tb/dual_bank_intc_test.sv
`timescale 1ns/1ps
module dual_bank_intc_test;
  localparam logic [7:0] N_SRC = 8'h00, N_MASK = 8'h04, N_CLR = 8'h08,
                         N_MODE = 8'h0C, N_POL = 8'h10, N_STAT = 8'h14;
  localparam logic [7:0] F_SRC = 8'h20, F_MASK = 8'h24, F_CLR = 8'h28,
                         F_MODE = 8'h2C, F_POL = 8'h30, F_STAT = 8'h34;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] lines_in = '0, wdata = '0, rdata;
  logic [7:0] addr = '0;
  logic irq_out, fiq_out;
  int checks = 0, errors = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  dual_bank_intc uut (
    .clk(clk), .rst_n(rst_n), .lines_in(lines_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .fiq_out(fiq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] regs [10] = '{N_MASK, N_MODE, N_POL, N_STAT, N_SRC,
                              F_MASK, F_MODE, F_POL, F_STAT, F_SRC};
    foreach (regs[i]) begin
      rd(regs[i], v); check("R1 reset register", v, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
    check("R1 fiq after reset", {31'b0, fiq_out}, 32'h0);
  endtask

  task automatic t_regmap();
    wr(N_MASK, 32'hA5A5_0F0F); wr(F_MODE, 32'h1234_5678); wr(F_POL, 32'h00FF_FF00);
    rd(N_MASK, v); check("R2 normal enable readback", v, 32'hA5A5_0F0F);
    rd(F_MODE, v); check("R2 fast mode readback", v, 32'h1234_5678);
    rd(F_POL, v);  check("R2 fast polarity readback", v, 32'h00FF_FF00);
    rd(F_MASK, v); check("R2 fast enable untouched", v, 32'h0);
    rd(N_MODE, v); check("R2 normal mode untouched", v, 32'h0);
    wr(N_MASK, 0); wr(F_MODE, 0); wr(F_POL, 0);
  endtask

  task automatic t_unmapped();
    wr(N_MASK, 32'hFFFF_FFFF);
    rd(8'h18, v); check("R8 offset 0x18", v, 0);
    rd(8'h1C, v); check("R8 offset 0x1C", v, 0);
    rd(8'h38, v); check("R8 offset 0x38", v, 0);
    rd(8'h44, v); check("R8 offset 0x44", v, 0);
    rd(8'h05, v); check("R8 unaligned offset", v, 0);
    rd(N_CLR, v); check("R8 acknowledge reads zero", v, 0);
    wr(N_MASK, 0);
  endtask

  task automatic t_level();
    wr(N_MASK, 32'hFFFF_FFFF);
    @(negedge clk); lines_in = 32'h1;
    @(negedge clk); check("R7 irq low after 1 edge", {31'b0, irq_out}, 0);
    @(negedge clk); check("R7 irq low after 2 edges", {31'b0, irq_out}, 0);
    @(negedge clk); check("R7 irq high after 3 edges", {31'b0, irq_out}, 1);
    check("R7 fiq untouched by normal bank", {31'b0, fiq_out}, 0);
    rd(N_STAT, v); check("R3 level pending", v, 32'h1);
    wr(N_CLR, 32'hFFFF_FFFF); settle();
    rd(N_STAT, v); check("R3 acknowledge ignored in level mode", v, 32'h1);
    check("R3 irq still high", {31'b0, irq_out}, 1);
    @(negedge clk); lines_in = 0; settle();
    rd(N_STAT, v); check("R3 level follows input low", v, 0);
    check("R3 irq low", {31'b0, irq_out}, 0);
    wr(N_POL, 32'h2); settle();
    rd(N_STAT, v); check("R3 active-low line pending", v, 32'h2);
    wr(N_POL, 32'h0F); wr(N_MASK, 32'h0F);
    @(negedge clk); lines_in = 32'hF0; settle();
    rd(N_SRC, v);  check("R6 raw view polarity adjusted", v, 32'hFF);
    rd(N_STAT, v); check("R6 masked view", v, 32'h0F);
    wr(N_MASK, 0); settle();
    check("R6 irq low when disabled", {31'b0, irq_out}, 0);
    wr(N_POL, 0);
    @(negedge clk); lines_in = 0; settle();
  endtask

  task automatic t_edge();
    wr(F_MODE, 32'hFFFF_FFFF); wr(F_POL, 32'h2); wr(F_CLR, 32'hFFFF_FFFF);
    wr(F_MASK, 32'hFFFF_FFFF); settle();
    rd(F_STAT, v); check("R4 nothing pending yet", v, 0);
    @(negedge clk); lines_in = 32'h1; settle();
    @(negedge clk); lines_in = 32'h0; settle();
    rd(F_STAT, v); check("R4 rising edge sticky", v, 32'h1);
    check("R7 fiq high", {31'b0, fiq_out}, 1);
    check("R7 irq untouched by fast bank", {31'b0, irq_out}, 0);
    @(negedge clk); lines_in = 32'h2; settle();
    rd(F_STAT, v); check("R4 rising ignored on falling line", v, 32'h1);
    @(negedge clk); lines_in = 32'h0; settle();
    rd(F_STAT, v); check("R4 falling edge sticky", v, 32'h3);
  endtask

  task automatic t_clear();
    wr(N_CLR, 32'hFFFF_FFFF); settle();
    rd(F_STAT, v); check("R5 other bank acknowledge no effect", v, 32'h3);
    wr(F_CLR, 32'h1); settle();
    rd(F_STAT, v); check("R5 clear one line", v, 32'h2);
    wr(F_CLR, 32'h0); settle();
    rd(F_STAT, v); check("R5 zero bits no effect", v, 32'h2);
    wr(F_CLR, 32'h2); settle();
    rd(F_STAT, v); check("R5 clear second line", v, 0);
    check("R5 fiq low", {31'b0, fiq_out}, 0);
  endtask

  task automatic t_collide();
    @(negedge clk); lines_in = 32'h8; settle();
    rd(F_STAT, v); check("R9 older line pending", v, 32'h8);
    @(negedge clk); lines_in = 32'hC;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1; addr = F_CLR; wdata = 32'hC;
    @(negedge clk); wr_en = 0;
    settle();
    rd(F_STAT, v); check("R9 new edge wins over acknowledge", v, 32'h4);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_unmapped();
    t_level();
    t_edge();
    t_clear();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule